// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It steps the analog front end through a repeating cycle of three phases: auto-zero, signal integrate and reference integrate. For each phase it raises one switch-enable output. A comparator bit shows which side of zero the integrator output is on. The block samples that bit to latch the input polarity. It then picks a reference sign that drives the integrator back toward zero, and counts how long the return takes. That count is the reading, and it equals the integrate length times the ratio of the input voltage to the reference voltage. The reading is given as sign and magnitude.

A divided clock tick, one per `CLK_DIV` oscillator cycles, is the unit of all phase timing. A frame is a fixed number of ticks. It starts at signal integrate, and whatever time reference integrate leaves unused becomes the following auto-zero. A steady frame rate keeps the signal integrate window at a fixed period, which is how the converter rejects mains interference. At the end of each reference integrate phase, the magnitude, the polarity and the overrange flag all update together. A one-cycle strobe marks each update.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_ni` is low, `az_en_o` is 1 and the outputs `si_en_o`, `ri_en_o`, `ref_neg_o`, `pol_o`, `ovr_o`, `valid_o` and `result_o` are all 0.
- R2: Exactly one of `az_en_o`, `si_en_o`, `ri_en_o` is high at any time. The phases run in the cycle auto-zero, signal integrate, reference integrate, and then back to auto-zero.
- R3: Signal integrate lasts exactly `INT_CNT` ticks, which is `INT_CNT*CLK_DIV` clock cycles.
- R4: At the end of signal integrate, the synchronised comparator value is latched. `cmp_i`=1 means the integrator is at or above zero. `pol_o`=1 reports a negative input, meaning the latched comparator value was 0. This holds even for inputs smaller than one LSB.
- R5: `ref_neg_o` is high only during reference integrate, and only when the latched comparator value was 1. This applies the reference with the sign opposite to the input.
- R6: Reference integrate ends at the first tick where the synchronised comparator differs from the latched value. `result_o` is then the number of whole ticks before that tick, and `ovr_o` is 0. The reading may lag the true crossing by up to two ticks.
- R7: If the comparator does not change within `DEINT_MAX` ticks, reference integrate ends after `DEINT_MAX` ticks. `result_o` is then `DEINT_MAX` and `ovr_o` is 1.
- R8: Consecutive rises of `si_en_o` are exactly `FRAME_CNT*CLK_DIV` clock cycles apart, whatever the readings are. Auto-zero lasts `FRAME_CNT-INT_CNT` minus the ticks used by the previous reference integrate phase.
- R9: `valid_o` is high for one cycle at the end of each reference integrate phase. `result_o`, `pol_o` and `ovr_o` change only in that cycle.
- R10: The first auto-zero after reset lasts `FRAME_CNT-INT_CNT` ticks. With `rst_ni` released between clock edges, `si_en_o` first rises after edge number `(FRAME_CNT-INT_CNT)*CLK_DIV` counted from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Comparator: 1 when integrator output is at or above zero |
| az_en_o | output | 1 | Auto-zero switch enable |
| si_en_o | output | 1 | Signal integrate switch enable |
| ri_en_o | output | 1 | Reference integrate switch enable |
| ref_neg_o | output | 1 | Apply negative reference during reference integrate |
| pol_o | output | 1 | Latched polarity, 1 = negative input |
| result_o | output | RES_W | Magnitude of the last reading |
| ovr_o | output | 1 | Last reading hit the de-integrate limit |
| valid_o | output | 1 | One-cycle strobe when a new reading is loaded |

## Verification
The hardest cases to reach are the ones where the comparator flips at a chosen moment: a sub-LSB input of either sign, a reading just under the de-integrate limit, and a missing crossing. The bench models the integrator behaviourally. It adds the applied input on every clock of signal integrate, steps by the selected reference on every clock of reference integrate, and clears during auto-zero. A chosen input value therefore produces a crossing at a known tick. The input values are picked so that the two-tick detection lag cannot blur the line between an in-range reading and an overrange one. The frame period is checked across long and short readings, which shows that auto-zero absorbs the slack.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {PH_AZ = 2'd0, PH_SI = 2'd1, PH_RI = 2'd2} phase_e;
endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       div_q <= '0;
    else if (div_q == W'(CLK_DIV - 1)) div_q <= '0;
    else                               div_q <= div_q + W'(1);
  end

  assign tick_o = (div_q == W'(CLK_DIV - 1));

  generate
    if (CLK_DIV > 1) begin : g_tick_chk
      // R3
      tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_phase_fsm.sv
module dslope_phase_fsm
  import dslope_pkg::*;
#(
  parameter int INT_CNT   = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int FRAME_CNT = 4000,
  parameter int RES_W     = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmp_s_i,
  output phase_e           phase_o,
  output logic             ref_neg_o,
  output logic [RES_W-1:0] result_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             valid_o
);
  localparam int CW = $clog2(FRAME_CNT + 1);
  localparam logic [CW-1:0] AZ_FIRST = CW'(FRAME_CNT - INT_CNT);
  localparam logic [CW-1:0] AZ_SLACK = CW'(FRAME_CNT - INT_CNT - 1);
  localparam logic [CW-1:0] AZ_SHORT = CW'(FRAME_CNT - INT_CNT - DEINT_MAX);

  phase_e           phase_q;
  logic [CW-1:0]    cnt_q, az_len_q;
  logic             sgn_q;
  logic [RES_W-1:0] result_q;
  logic             pol_q, ovr_q, valid_q;
  logic             crossed;

  assign crossed = (cmp_s_i != sgn_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_AZ;
      cnt_q    <= '0;
      az_len_q <= AZ_FIRST;
      sgn_q    <= 1'b0;
      result_q <= '0;
      pol_q    <= 1'b0;
      ovr_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        unique case (phase_q)
          PH_AZ: begin
            if (cnt_q == az_len_q - CW'(1)) begin
              phase_q <= PH_SI;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CW'(1);
          end
          PH_SI: begin
            if (cnt_q == CW'(INT_CNT - 1)) begin
              sgn_q   <= cmp_s_i;
              phase_q <= PH_RI;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CW'(1);
          end
          PH_RI: begin
            if (crossed || cnt_q == CW'(DEINT_MAX - 1)) begin
              // auto-zero takes the remainder of the frame
              result_q <= crossed ? RES_W'(cnt_q) : RES_W'(DEINT_MAX);
              ovr_q    <= !crossed;
              az_len_q <= crossed ? (AZ_SLACK - cnt_q) : AZ_SHORT;
              pol_q    <= !sgn_q;
              valid_q  <= 1'b1;
              phase_q  <= PH_AZ;
              cnt_q    <= '0;
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: begin
            phase_q <= PH_AZ;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  assign phase_o   = phase_q;
  assign ref_neg_o = (phase_q == PH_RI) && sgn_q;
  assign result_o  = result_q;
  assign pol_o     = pol_q;
  assign ovr_o     = ovr_q;
  assign valid_o   = valid_q;

  // R2
  ri_after_si_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RI && $past(phase_q) != PH_RI) |-> $past(phase_q) == PH_SI);
  // R2
  si_after_az_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SI && $past(phase_q) != PH_SI) |-> $past(phase_q) == PH_AZ);
  // R6
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_q <= RES_W'(DEINT_MAX));
  // R7
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ovr_q) |-> result_q == RES_W'(DEINT_MAX));
  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R9
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(result_q) && $stable(pol_q) && $stable(ovr_q)));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int INT_CNT     = 1000,
  parameter int DEINT_MAX   = 2000,
  parameter int FRAME_CNT   = 4000,
  parameter int SYNC_STAGES = 2,
  parameter int RES_W       = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  output logic             az_en_o,
  output logic             si_en_o,
  output logic             ri_en_o,
  output logic             ref_neg_o,
  output logic             pol_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             valid_o
);
  logic   tick, cmp_s;
  phase_e phase;

  dslope_prescale #(.CLK_DIV(CLK_DIV)) u_prescale (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cmp_i), .q_o(cmp_s)
  );

  dslope_phase_fsm #(
    .INT_CNT(INT_CNT), .DEINT_MAX(DEINT_MAX),
    .FRAME_CNT(FRAME_CNT), .RES_W(RES_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cmp_s_i  (cmp_s),
    .phase_o  (phase),
    .ref_neg_o(ref_neg_o),
    .result_o (result_o),
    .pol_o    (pol_o),
    .ovr_o    (ovr_o),
    .valid_o  (valid_o)
  );

  assign az_en_o = (phase == PH_AZ);
  assign si_en_o = (phase == PH_SI);
  assign ri_en_o = (phase == PH_RI);

  // R2
  phase_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({az_en_o, si_en_o, ri_en_o}));
  // R5
  ref_in_ri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_neg_o |-> ri_en_o);
endmodule

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
  localparam int DIV = 4, INTC = 20, DMAX = 40, FRM = 80;
  localparam int RW = $clog2(DMAX + 1);
  localparam int REF_STEP = INTC * DIV;
  localparam int NV = 13;
  localparam int VIN_TAB [NV] = '{0, 1, -1, 3, 40, -40, 100, -100, 150, -150, 200, -200, 600};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp;
  logic az_en, si_en, ri_en, ref_neg, pol, ovr, valid;
  logic [RW-1:0] result;

  int n_chk = 0, n_err = 0, ncyc = 0, si_last = -1, wd = 0;
  int v = 0, vin = 0;
  logic si_prev = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (v >= 0);

  dslope_seq #(.CLK_DIV(DIV), .INT_CNT(INTC), .DEINT_MAX(DMAX), .FRAME_CNT(FRM)) u_dslope_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
    .az_en_o(az_en), .si_en_o(si_en), .ri_en_o(ri_en), .ref_neg_o(ref_neg),
    .pol_o(pol), .result_o(result), .ovr_o(ovr), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // integrator model and frame monitor
  always @(negedge clk) begin
    ncyc++;
    if (!rst_n || az_en) v = 0;
    else if (si_en)      v = v + vin;
    else if (ri_en)      v = ref_neg ? v - REF_STEP : v + REF_STEP;
    if (rst_n) begin
      chk((az_en + si_en + ri_en) == 1, "R2 one phase", az_en + si_en + ri_en, 1);
      if (si_en && !si_prev) begin
        if (si_last >= 0) chk(ncyc - si_last == FRM * DIV, "R8 frame period", ncyc - si_last, FRM * DIV);
        si_last = ncyc;
      end
      si_prev = si_en;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wait_valid();
    @(negedge clk);
    while (!valid) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(az_en == 1'b1, "R1 az_en", az_en, 1);
    chk({si_en, ri_en, ref_neg, pol, ovr, valid} == 6'b0, "R1 flags", {si_en, ri_en, ref_neg, pol, ovr, valid}, 0);
    chk(result == '0, "R1 result", result, 0);
    rst_n = 1'b1;
    // R10 first auto-zero length
    n = 0;
    do begin @(negedge clk); n++; end while (!si_en);
    chk(n == (FRM - INTC) * DIV, "R10 first auto-zero", n, (FRM - INTC) * DIV);
    // R3 signal integrate length
    n = 0;
    while (si_en) begin @(negedge clk); n++; end
    chk(n == INTC * DIV, "R3 integrate clocks", n, INTC * DIV);

    wait_valid();
    for (int i = 0; i < NV; i++) begin
      int mag, exp_r;
      bit exp_ovr, exp_pol;
      vin = VIN_TAB[i];
      mag = (vin < 0) ? -vin : vin;
      exp_r = mag / DIV;
      exp_ovr = (exp_r >= DMAX);
      exp_pol = (vin < 0);
      // R5 reference sign during the next reference integrate
      while (!ri_en) @(negedge clk);
      while (!ri_en) @(negedge clk);
      @(negedge clk);
      if (ri_en) chk(ref_neg == !exp_pol, "R5 reference sign", ref_neg, !exp_pol);
      while (!valid) @(negedge clk);
      // first strobe may belong to a frame started before vin changed
      if (i == 0) wait_valid();
      else if (!si_prev) ; 
      chk(pol == exp_pol, "R4 polarity", pol, exp_pol);
      chk(ovr == exp_ovr, exp_ovr ? "R7 overrange flag" : "R6 in-range flag", ovr, exp_ovr);
      if (exp_ovr) chk(result == RW'(DMAX), "R7 clamped result", result, DMAX);
      else chk(result >= RW'(exp_r) && result <= RW'(exp_r + 2), "R6 reading", result, exp_r);
      @(negedge clk);
      chk(valid == 1'b0, "R9 strobe width", valid, 0);
      chk(ref_neg == 1'b0, "R5 reference off in auto-zero", ref_neg, 0);
      wait_valid();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule